// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register-side core of a 128-pin general-purpose I/O controller. The pins are split into four banks of 32. Pin n sits in bank n>>5 at bit n&31. A simple synchronous register bus writes and reads the per-bank state: direction, output latch, rising and falling edge enables, and two alternate-function words. The output latch is never written directly. Software changes it through an atomic set register and an atomic clear register.

The block drives each pin's output value and output enable. It passes the raw pin inputs through a two-flop synchronizer. A read of a bank's level register returns, bit by bit, the latch value for output pins and the synchronized input for input pins.

Edge-status storage lives in a neighbouring block. This block reads that block's status vector and hands back one-cycle clear strobes. It also exports the edge enables and the synchronized inputs. The alternate-function words are plain storage.

The register map is irregular. Banks 0 to 2 are packed low. Bank 3 sits 0x100 higher. The alternate-function words of all banks are interleaved in a separate window.

Top module: `gpio_bank_regfile`

## Requirements
- R1: `pin_oe` equals the direction register (1 = output), and `pin_out` equals the output latch ANDed with direction. An input pin therefore never drives a 1.
- R2: Writing the set register ORs the written value into that bank's latch. The register reads as zero. Addresses: bank 0/1/2 at 0x018/0x01C/0x020, bank 3 at 0x118.
- R3: Writing the clear register removes the written 1-bits from that bank's latch. The register reads as zero. Addresses: bank 0/1/2 at 0x024/0x028/0x02C, bank 3 at 0x124.
- R4: A level-register read returns `(latch & dir) | (sync_in & ~dir)`. Level registers are at 0x000/0x004/0x008 for banks 0 to 2 and 0x100 for bank 3. A read issued in the same cycle as a pin change still sees the old value. A read issued two cycles later sees the new value, and `pin_sync` shows it by then.
- R5: Direction registers (0x00C/0x010/0x014/0x10C) read back what was written. So do the alternate-function words: low word at 0x054+8*b, high word at 0x058+8*b, for bank b.
- R6: The rising-enable registers (0x030/0x034/0x038/0x130) and falling-enable registers (0x03C/0x040/0x044/0x13C) read back what was written. They appear on `rise_en` and `fall_en` at the pin positions of their bank.
- R7: An edge-status read (0x048/0x04C/0x050/0x148) returns that bank's slice of `edge_status`. A write there pulses `edge_clr` with the written bits in that bank's slice for exactly one cycle, in the cycle after the write. All other bits stay zero.
- R8: Any access at offset 0x200 or above reads zero, changes no state, and raises no error.
- R9: An access below 0x200 that hits no register reads zero and changes no state. This includes a misaligned offset. It raises `acc_err` for one cycle, in the cycle after the request.
- R10: After reset, direction, latch, edge enables and alternate-function words are all zero, so `pin_oe`, `pin_out`, `rise_en` and `fall_en` are zero.
- R11: `rd_valid` is high for one cycle after each read request, with `rd_data` valid in that cycle. A write never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Unmapped-access pulse |
| pin_in | input | 128 | Raw pin inputs |
| pin_out | output | 128 | Pin output values |
| pin_oe | output | 128 | Pin output enables |
| rise_en | output | 128 | Rising-edge enables |
| fall_en | output | 128 | Falling-edge enables |
| pin_sync | output | 128 | Synchronized pin inputs |
| edge_status | input | 128 | Edge status from the neighbouring block |
| edge_clr | output | 128 | One-cycle edge-status clear strobes |

## Verification
The assertions check the following on every cycle:
- no input pin ever drives a 1;
- a bank-0 set or clear write is reflected on the pins in the next cycle;
- out-of-window writes leave every pin-side output stable;
- `rd_valid`, `acc_err` and `edge_clr` only follow a matching request.

Some behaviour only the bench scenarios can show:
- the bank-3 and interleaved alternate-function offsets;
- the per-bit level mix;
- the two-cycle synchronizer latency;
- the aliasing-free handling of offsets above 0x200;
- that hole writes leave stored state untouched.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  localparam int NBANK  = 4;
  localparam int BANK_W = 32;
  localparam int BSEL_W = $clog2(NBANK);

  typedef enum logic [3:0] {
    K_NONE, K_LVL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_EDGE, K_AFL, K_AFH
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [BSEL_W-1:0] bank;
    logic              hole;   // below the window top but no register
  } dec_t;

  // Banks 0-2: group g, bank b at 4*(3g+b). Bank 3: 0x100 + 12g.
  // Group order: level, dir, set, clr, rise, fall, edge.
  // Alternate-function words are interleaved from 0x054.
  function automatic dec_t decode(input logic [31:0] a);
    dec_t d;
    logic [31:0] idx;
    d.kind = K_NONE;
    d.bank = '0;
    d.hole = 1'b0;
    if (a >= 32'h200) return d;
    d.hole = 1'b1;
    if (a[1:0] != 2'b00) return d;
    if (a < 32'h54) begin
      idx    = a >> 2;
      d.kind = kind_e'(4'(idx / 3 + 1));
      d.bank = BSEL_W'(idx % 3);
      d.hole = 1'b0;
    end else if (a <= 32'h70) begin
      idx    = (a - 32'h54) >> 2;
      d.kind = ((idx & 32'd1) != 0) ? K_AFH : K_AFL;
      d.bank = BSEL_W'(idx >> 1);
      d.hole = 1'b0;
    end else if (a >= 32'h100 && a <= 32'h148) begin
      idx = (a - 32'h100) >> 2;
      if (idx % 3 == 0) begin
        d.kind = kind_e'(4'(idx / 3 + 1));
        d.bank = BSEL_W'(NBANK - 1);
        d.hole = 1'b0;
      end
    end
    return d;
  endfunction

  function automatic logic [BANK_W-1:0] lvl_mix(input logic [BANK_W-1:0] lat,
                                                input logic [BANK_W-1:0] dir,
                                                input logic [BANK_W-1:0] smp);
    return (lat & dir) | (smp & ~dir);
  endfunction
endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode import gpio_rf_pkg::*; #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  always_comb dec = decode(32'(addr));
endmodule

// File: rtl/gpio_rf_sync.sv
module gpio_rf_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gpio_rf_bank.sv
module gpio_rf_bank import gpio_rf_pkg::*; #(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  kind_e        kind,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir,
  output logic [W-1:0] olat,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall,
  output logic [W-1:0] afl,
  output logic [W-1:0] afh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '0;
      olat <= '0;
      rise <= '0;
      fall <= '0;
      afl  <= '0;
      afh  <= '0;
    end else if (we) begin
      case (kind)
        K_DIR:  dir  <= wdata;
        K_SET:  olat <= olat | wdata;
        K_CLR:  olat <= olat & ~wdata;
        K_RISE: rise <= wdata;
        K_FALL: fall <= wdata;
        K_AFL:  afl  <= wdata;
        K_AFH:  afh  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile import gpio_rf_pkg::*; #(
  parameter  int ADDR_W = 12,
  localparam int NPIN   = NBANK * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [BANK_W-1:0] rd_data,
  output logic              acc_err,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   rise_en,
  output logic [NPIN-1:0]   fall_en,
  output logic [NPIN-1:0]   pin_sync,
  input  logic [NPIN-1:0]   edge_status,
  output logic [NPIN-1:0]   edge_clr
);
  dec_t dec;
  logic wr_fire, rd_fire, hole_hit;
  logic [BANK_W-1:0] rd_mux;
  logic [BANK_W-1:0] dir_a [NBANK];
  logic [BANK_W-1:0] olat_a[NBANK];
  logic [BANK_W-1:0] rise_a[NBANK];
  logic [BANK_W-1:0] fall_a[NBANK];
  logic [BANK_W-1:0] afl_a [NBANK];
  logic [BANK_W-1:0] afh_a [NBANK];
  logic [BANK_W-1:0] sync_a[NBANK];
  logic [BANK_W-1:0] edge_a[NBANK];

  gpio_rf_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(req_addr), .dec(dec));

  gpio_rf_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign wr_fire  = req_valid & req_write;
  assign rd_fire  = req_valid & ~req_write;
  assign hole_hit = req_valid & dec.hole;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_fire && (dec.kind != K_NONE) && (dec.bank == BSEL_W'(b));

    gpio_rf_bank #(.W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_we), .kind(dec.kind), .wdata(req_wdata),
      .dir(dir_a[b]), .olat(olat_a[b]), .rise(rise_a[b]), .fall(fall_a[b]),
      .afl(afl_a[b]), .afh(afh_a[b])
    );

    assign sync_a[b] = pin_sync[b*BANK_W +: BANK_W];
    assign edge_a[b] = edge_status[b*BANK_W +: BANK_W];
    assign pin_oe [b*BANK_W +: BANK_W] = dir_a[b];
    assign pin_out[b*BANK_W +: BANK_W] = olat_a[b] & dir_a[b];
    assign rise_en[b*BANK_W +: BANK_W] = rise_a[b];
    assign fall_en[b*BANK_W +: BANK_W] = fall_a[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_clr[b*BANK_W +: BANK_W] <= '0;
      else if (bank_we && dec.kind == K_EDGE) edge_clr[b*BANK_W +: BANK_W] <= req_wdata;
      else edge_clr[b*BANK_W +: BANK_W] <= '0;
    end
  end

  always_comb begin
    case (dec.kind)
      K_LVL:   rd_mux = lvl_mix(olat_a[dec.bank], dir_a[dec.bank], sync_a[dec.bank]);
      K_DIR:   rd_mux = dir_a[dec.bank];
      K_RISE:  rd_mux = rise_a[dec.bank];
      K_FALL:  rd_mux = fall_a[dec.bank];
      K_EDGE:  rd_mux = edge_a[dec.bank];
      K_AFL:   rd_mux = afl_a[dec.bank];
      K_AFH:   rd_mux = afh_a[dec.bank];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      rd_data  <= rd_fire ? rd_mux : '0;
      acc_err  <= hole_hit;
    end
  end
endmodule

// File: rtl/gpio_rf_chk.sv
module gpio_rf_chk #(
  parameter int ADDR_W = 12,
  parameter int NPIN   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              acc_err,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   rise_en,
  input logic [NPIN-1:0]   fall_en,
  input logic [NPIN-1:0]   edge_clr
);
  // R1
  no_float_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R2
  set_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'('h018)) |=>
      ((pin_out[31:0] & $past(req_wdata)) == (pin_oe[31:0] & $past(req_wdata))));

  // R2
  set_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == ADDR_W'('h018)) |=> (rd_data == '0));

  // R3
  clr_remove_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'('h024)) |=>
      ((pin_out[31:0] & $past(req_wdata)) == '0));

  // R8
  far_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr >= ADDR_W'('h200)) |=>
      ($stable(pin_out) && $stable(pin_oe) && $stable(rise_en) && $stable(fall_en) && !acc_err));

  // R9
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(req_valid));

  // R11
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  // R7
  edge_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_clr != '0) |-> $past(req_valid && req_write));
endmodule

bind gpio_bank_regfile gpio_rf_chk #(.ADDR_W(ADDR_W), .NPIN(NPIN)) u_chk (.*);

// File: tb/tb_gpio_bank_regfile.sv
module tb_gpio_bank_regfile;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rd_valid, acc_err;
  logic [31:0]  rd_data;
  logic [127:0] pin_in = '0;
  logic [127:0] edge_status = '0;
  logic [127:0] pin_out, pin_oe, rise_en, fall_en, pin_sync, edge_clr;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  gpio_bank_regfile dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .acc_err(acc_err), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .rise_en(rise_en), .fall_en(fall_en), .pin_sync(pin_sync),
    .edge_status(edge_status), .edge_clr(edge_clr)
  );

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: called on a falling edge, returns on a falling edge
  task automatic rd(logic [11:0] a, logic [31:0] exp, logic err, string tag);
    exp_t e;
    e.data = exp;
    e.err  = err;
    e.tag  = tag;
    sb.push_back(e);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (sb.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R11 unexpected rd_valid act=1 exp=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, {96'b0, rd_data}, {96'b0, e.data});
          check({e.tag, " err"}, {127'b0, acc_err}, {127'b0, e.err});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 pin_oe", pin_oe, '0);
    check("R10 pin_out", pin_out, '0);
    check("R10 rise_en", rise_en, '0);
    check("R10 fall_en", fall_en, '0);
    rd(12'h00C, 32'h0, 1'b0, "R10 dir0 reset");
    rd(12'h070, 32'h0, 1'b0, "R10 alt3 high reset");

    // R5 direction and R1 enables
    wr(12'h00C, 32'h0000FFFF);
    check("R11 no rd_valid after write", {127'b0, rd_valid}, '0);
    wr(12'h10C, 32'hF0F0F0F0);
    rd(12'h00C, 32'h0000FFFF, 1'b0, "R5 dir bank0");
    rd(12'h10C, 32'hF0F0F0F0, 1'b0, "R5 dir bank3");
    check("R1 pin_oe", pin_oe, {32'hF0F0F0F0, 64'h0, 32'h0000FFFF});

    // R2 set
    wr(12'h018, 32'h00FF00FF);
    check("R2 set bank0 pins", {96'b0, pin_out[31:0]}, {96'b0, 32'h000000FF});
    wr(12'h118, 32'hFFFFFFFF);
    check("R2 set bank3 pins", {96'b0, pin_out[127:96]}, {96'b0, 32'hF0F0F0F0});
    rd(12'h018, 32'h0, 1'b0, "R2 set reads zero");

    // R3 clear
    wr(12'h024, 32'h0000000F);
    check("R3 clear bank0 pins", {96'b0, pin_out[31:0]}, {96'b0, 32'h000000F0});
    rd(12'h024, 32'h0, 1'b0, "R3 clear reads zero");
    check("R1 no drive on inputs", pin_out & ~pin_oe, '0);

    // R4 level mix
    pin_in[31:0]   = 32'hA5A5A5A5;
    pin_in[127:96] = 32'h12345678;
    repeat (4) @(negedge clk);
    check("R4 pin_sync", pin_sync, pin_in);
    rd(12'h000, 32'hA5A500F0, 1'b0, "R4 level bank0");
    rd(12'h100, 32'hF2F4F6F8, 1'b0, "R4 level bank3");

    // R4 synchronizer latency
    pin_in[63:32] = 32'hFFFFFFFF;
    rd(12'h004, 32'h0, 1'b0, "R4 same-cycle read old");
    rd(12'h004, 32'h0, 1'b0, "R4 next-cycle read old");
    rd(12'h004, 32'hFFFFFFFF, 1'b0, "R4 third read new");

    // R6 edge enables
    wr(12'h034, 32'h11112222);
    wr(12'h13C, 32'hDEADBEEF);
    check("R6 rise_en", rise_en, {64'h0, 32'h11112222, 32'h0});
    check("R6 fall_en", fall_en, {32'hDEADBEEF, 96'h0});
    rd(12'h034, 32'h11112222, 1'b0, "R6 rise bank1");
    rd(12'h13C, 32'hDEADBEEF, 1'b0, "R6 fall bank3");

    // R5 alternate-function interleave
    wr(12'h054, 32'h1);
    wr(12'h05C, 32'h2);
    wr(12'h070, 32'h7);
    rd(12'h054, 32'h1, 1'b0, "R5 alt0 low");
    rd(12'h058, 32'h0, 1'b0, "R5 alt0 high");
    rd(12'h05C, 32'h2, 1'b0, "R5 alt1 low");
    rd(12'h070, 32'h7, 1'b0, "R5 alt3 high");
    rd(12'h06C, 32'h0, 1'b0, "R5 alt3 low");

    // R7 edge status pass-through and clear strobe
    edge_status = {32'h0BAD0000, 32'h0, 32'hCAFE1234, 32'h0};
    rd(12'h04C, 32'hCAFE1234, 1'b0, "R7 edge read bank1");
    rd(12'h148, 32'h0BAD0000, 1'b0, "R7 edge read bank3");
    wr(12'h148, 32'h0000FF00);
    check("R7 edge_clr pulse", edge_clr, {32'h0000FF00, 96'h0});
    @(negedge clk);
    check("R7 edge_clr one cycle", edge_clr, '0);

    // R8 outside the window
    wr(12'h218, 32'hFFFFFFFF);
    check("R8 far write no err", {127'b0, acc_err}, '0);
    check("R8 far write pins", pin_out, {32'hF0F0F0F0, 64'h0, 32'h000000F0});
    wr(12'h30C, 32'h0);
    check("R8 far write dir", pin_oe, {32'hF0F0F0F0, 64'h0, 32'h0000FFFF});
    rd(12'h200, 32'h0, 1'b0, "R8 far read 0x200");
    rd(12'h30C, 32'h0, 1'b0, "R8 far read alias");

    // R9 holes
    rd(12'h0A0, 32'h0, 1'b1, "R9 hole read");
    rd(12'h1F0, 32'h0, 1'b1, "R9 hole read high");
    rd(12'h00E, 32'h0, 1'b1, "R9 misaligned read");
    wr(12'h074, 32'hFFFFFFFF);
    check("R9 hole write err", {127'b0, acc_err}, {127'b0, 1'b1});
    @(negedge clk);
    check("R9 err one cycle", {127'b0, acc_err}, '0);
    wr(12'h110, 32'h0);
    check("R9 hole write no effect", pin_oe, {32'hF0F0F0F0, 64'h0, 32'h0000FFFF});
    rd(12'h074, 32'h0, 1'b1, "R9 hole reads zero");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", 128'(sb.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule